// File: doc/BRIEF.md
# Two-Counter Event Monitor

This block counts hardware events on two programmable counters. Every cycle, a set of event lanes presents one event per lane. Each event has an 8-bit code, an 8-bit sub-type vector and a small occurrence count. Each counter has a 32-bit selector register that picks the events it counts. The selector names an event code and a sub-type mask, and it can apply a threshold, invert the threshold test, or count only rising transitions. A write port and a separate combinational read port give access to both selectors, both counters and an overflow status word.

One run bit, held only in selector 0, starts and stops both counters together. A counter is stopped on its own by loading the no-count setting into its selector. Some event codes are tied to one counter and never advance the other. Counters read back as 40 bits: the top byte copies bit 31. Software loads a negated period so that the counter wraps after that many events. A wrap sets a sticky overflow flag, and the interrupt request is high while either flag is set.

The selected events feed two small state machines per counter:

- **Edge tracker**, with states `EDGE_LOW` and `EDGE_HIGH`. The tracker enters `EDGE_HIGH` when the qualified condition is true and returns to `EDGE_LOW` when it is false. A rising transition is the move from `EDGE_LOW` into `EDGE_HIGH`.
- **Overflow tracker**, with states `OVF_IDLE` and `OVF_PEND`. A counted carry out of bit 31 moves it from `OVF_IDLE` to `OVF_PEND`. A clear with no new carry in the same cycle moves it from `OVF_PEND` back to `OVF_IDLE`.

Top module: `pmu2_top`

## Requirements
- R1: The registers are at these write/read addresses: 0 is selector 0, 1 is selector 1, 2 is counter 0, 3 is counter 1 and 4 is overflow status. A selector reads back as the 32 bits last written, zero-extended to 40 bits. The status word is {38'b0, ovf1, ovf0}. All registers reset to zero.
- R2: The selector fields are code [7:0], sub-type mask [15:8], edge [18], pin-control [19] (stored only), run [22], invert [23] and threshold [31:24]. A lane matches when its code equals the selector code and its sub-type vector shares a set bit with the mask, or the mask is 0xFF. With threshold 0 and edge clear, a running counter adds the sum of the occurrence counts of all matching lanes at each clock edge.
- R3: Both counters advance only while bit 22 of selector 0 is set. Bit 22 of selector 1 has no effect.
- R4: A counter reads back as 40 bits, with bits 39:32 equal to bit 31.
- R5: Selector code 0x2E with a sub-type mask of 0x00 matches nothing, so that counter holds its value.
- R6: Codes 0xC1, 0x10 and 0x14 advance only counter 0. Codes 0x11, 0x12 and 0x13 advance only counter 1. Loaded on the other counter, these codes count nothing.
- R7: With a nonzero threshold, a cycle adds 1 when the matching sum is at or above the threshold, and 0 otherwise. Invert (bit 23) turns the test into "below the threshold".
- R8: With edge set, a cycle adds 1 only on a rising transition of the qualified condition. Without a threshold, that condition is "matching sum nonzero".
- R9: A counted carry out of bit 31 sets that counter's sticky overflow flag. The flag stays set until a write of 1 to its bit at address 4 (bit 0 for counter 0, bit 1 for counter 1). The interrupt request is high while either flag is set.
- R10: A counter write stores the low 32 bits of the data. In the same cycle it takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 40 | Combinational read data |
| ev_code | input | LANES*8 | Event code per lane |
| ev_sub | input | LANES*8 | Sub-type vector per lane |
| ev_occ | input | LANES*OCC_W | Occurrence count per lane this cycle |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench sets lanes whose code matches but whose sub-type bits do not overlap the mask. A design that ignores the mask would count them. It sets the run bit in selector 1 alone and then loads restricted codes on the wrong counter; a design that honours that bit, or drops the routing rule, would keep counting. Occurrence sequences straddle the threshold both plain and inverted, and held-high runs test edge mode; an off-by-one compare or a level-sensitive edge would give the wrong totals. The bench also preloads near-wrap values, writes a counter while events are active, and reads values with bit 31 set. A design that lost the sticky flag, let counting win over the write, or zero-filled the top byte would show it there.

// File: rtl/pmu2_pkg.sv
`timescale 1ns/1ps
package pmu2_pkg;

    localparam int CNT_W = 32;
    localparam int RD_W  = 40;

    localparam logic [2:0] ADR_SEL0 = 3'd0;
    localparam logic [2:0] ADR_SEL1 = 3'd1;
    localparam logic [2:0] ADR_CNT0 = 3'd2;
    localparam logic [2:0] ADR_CNT1 = 3'd3;
    localparam logic [2:0] ADR_OVF  = 3'd4;

    localparam logic [7:0] QUIET_CODE = 8'h2E;
    localparam logic [7:0] ALL_SUBS   = 8'hFF;

    typedef struct packed {
        logic [7:0] cmask;
        logic       inv;
        logic       run;
        logic [1:0] rsvd_hi;
        logic       pin_ctl;
        logic       edge_det;
        logic [1:0] rsvd_lo;
        logic [7:0] umask;
        logic [7:0] code;
    } sel_t;

    typedef enum logic { EDGE_LOW, EDGE_HIGH } edge_state_t;
    typedef enum logic { OVF_IDLE, OVF_PEND } ovf_state_t;

    function automatic logic code_allowed(input int idx, input logic [7:0] code);
        logic ok;
        unique case (code)
            8'hC1, 8'h10, 8'h14: ok = (idx == 0);
            8'h11, 8'h12, 8'h13: ok = (idx == 1);
            default:             ok = 1'b1;
        endcase
        return ok;
    endfunction

    function automatic logic is_quiet(input logic [7:0] code, input logic [7:0] umask);
        return (code == QUIET_CODE) && (umask == 8'h00);
    endfunction

endpackage

// File: rtl/pmu2_match.sv
`timescale 1ns/1ps
module pmu2_match
    import pmu2_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OCC_W = 3,
    parameter int IDX   = 0,
    parameter int SUM_W = 6
) (
    input  logic [7:0]             sel_code,
    input  logic [7:0]             sel_umask,
    input  logic [LANES*8-1:0]     ev_code,
    input  logic [LANES*8-1:0]     ev_sub,
    input  logic [LANES*OCC_W-1:0] ev_occ,
    output logic [SUM_W-1:0]       raw
);

    logic permit;
    logic hit;

    always_comb begin
        permit = code_allowed(IDX, sel_code) && !is_quiet(sel_code, sel_umask);
        raw    = '0;
        hit    = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            hit = (ev_code[i*8 +: 8] == sel_code) &&
                  ((sel_umask == ALL_SUBS) || ((ev_sub[i*8 +: 8] & sel_umask) != 8'h00));
            if (hit && permit) begin
                raw = raw + SUM_W'(ev_occ[i*OCC_W +: OCC_W]);
            end
        end
    end

endmodule

// File: rtl/pmu2_qual.sv
`timescale 1ns/1ps
module pmu2_qual
    import pmu2_pkg::*;
#(
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cmask,
    input  logic             inv,
    input  logic             edge_det,
    input  logic [SUM_W-1:0] raw,
    output logic [SUM_W-1:0] inc
);

    localparam int CMP_W = (SUM_W > 8) ? SUM_W : 8;

    edge_state_t st_q, st_d;
    logic        cond;
    logic        fire;
    logic [CMP_W-1:0] raw_x;
    logic [CMP_W-1:0] thr_x;

    always_comb begin
        raw_x = CMP_W'(raw);
        thr_x = CMP_W'(cmask);
        if (cmask == 8'h00) begin
            cond = (raw != '0);
        end else if (inv) begin
            cond = (raw_x < thr_x);
        end else begin
            cond = (raw_x >= thr_x);
        end
    end

    always_comb begin
        unique case (st_q)
            EDGE_LOW:  st_d = cond ? EDGE_HIGH : EDGE_LOW;
            EDGE_HIGH: st_d = cond ? EDGE_HIGH : EDGE_LOW;
            default:   st_d = EDGE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EDGE_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        fire = edge_det ? (cond && (st_q == EDGE_LOW)) : cond;
        if ((cmask == 8'h00) && !edge_det) begin
            inc = raw;
        end else begin
            inc = SUM_W'(fire);
        end
    end

    p_unit_thresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmask != 8'h00) |-> (inc <= SUM_W'(1)));

    p_edge_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_det && inc != '0) |=>
        (!edge_det || !$stable(cmask) || !$stable(inv) || inc == '0));

endmodule

// File: rtl/pmu2_counter.sv
`timescale 1ns/1ps
module pmu2_counter
    import pmu2_pkg::*;
#(
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SUM_W-1:0] inc,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [CNT_W:0] sum;
    logic           carry;
    ovf_state_t     st_q, st_d;

    always_comb begin
        sum   = {1'b0, cnt} + (CNT_W+1)'(inc);
        carry = run && !wr_cnt && sum[CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_cnt) begin
            cnt <= wr_data;
        end else if (run) begin
            cnt <= sum[CNT_W-1:0];
        end
    end

    always_comb begin
        unique case (st_q)
            OVF_IDLE: st_d = carry ? OVF_PEND : OVF_IDLE;
            OVF_PEND: st_d = (clr_ovf && !carry) ? OVF_IDLE : OVF_PEND;
            default:  st_d = OVF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= OVF_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ovf = (st_q == OVF_PEND);
    end

    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wr_data)));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);

    p_wrap_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_cnt && cnt == {CNT_W{1'b1}} && inc != '0) |=> ovf);

endmodule

// File: rtl/pmu2_top.sv
`timescale 1ns/1ps
module pmu2_top
    import pmu2_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OCC_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2:0]             wr_addr,
    input  logic [31:0]            wr_data,
    input  logic [2:0]             rd_addr,
    output logic [39:0]            rd_data,
    input  logic [LANES*8-1:0]     ev_code,
    input  logic [LANES*8-1:0]     ev_sub,
    input  logic [LANES*OCC_W-1:0] ev_occ,
    output logic                   irq
);

    localparam int SUM_W = OCC_W + $clog2(LANES + 1);
    localparam int NCTR  = 2;
    localparam int EXT_W = RD_W - CNT_W;

    sel_t             sel_q  [NCTR];
    logic [CNT_W-1:0] cnt_w  [NCTR];
    logic [SUM_W-1:0] raw_w  [NCTR];
    logic [SUM_W-1:0] inc_w  [NCTR];
    logic [NCTR-1:0]  ovf_w;
    logic [NCTR-1:0]  wr_cnt;
    logic             run;

    assign run = sel_q[0].run;

    for (genvar k = 0; k < NCTR; k++) begin : g_ctr
        localparam logic [2:0] SEL_ADR = ADR_SEL0 + 3'(k);
        localparam logic [2:0] CNT_ADR = ADR_CNT0 + 3'(k);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[k] <= '0;
            end else if (wr_en && wr_addr == SEL_ADR) begin
                sel_q[k] <= sel_t'(wr_data);
            end
        end

        assign wr_cnt[k] = wr_en && (wr_addr == CNT_ADR);

        pmu2_match #(
            .LANES (LANES),
            .OCC_W (OCC_W),
            .IDX   (k),
            .SUM_W (SUM_W)
        ) u_match (
            .sel_code  (sel_q[k].code),
            .sel_umask (sel_q[k].umask),
            .ev_code   (ev_code),
            .ev_sub    (ev_sub),
            .ev_occ    (ev_occ),
            .raw       (raw_w[k])
        );

        pmu2_qual #(
            .SUM_W (SUM_W)
        ) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmask    (sel_q[k].cmask),
            .inv      (sel_q[k].inv),
            .edge_det (sel_q[k].edge_det),
            .raw      (raw_w[k]),
            .inc      (inc_w[k])
        );

        pmu2_counter #(
            .SUM_W (SUM_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .inc     (inc_w[k]),
            .wr_cnt  (wr_cnt[k]),
            .wr_data (wr_data),
            .clr_ovf (wr_en && (wr_addr == ADR_OVF) && wr_data[k]),
            .cnt     (cnt_w[k]),
            .ovf     (ovf_w[k])
        );

        p_quiet_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (is_quiet(sel_q[k].code, sel_q[k].umask) && !wr_cnt[k]) |=> $stable(cnt_w[k]));

        p_routing_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!code_allowed(k, sel_q[k].code) && !wr_cnt[k]) |=> $stable(cnt_w[k]));
    end

    always_comb begin
        unique case (rd_addr)
            ADR_SEL0: rd_data = {{EXT_W{1'b0}}, sel_q[0]};
            ADR_SEL1: rd_data = {{EXT_W{1'b0}}, sel_q[1]};
            ADR_CNT0: rd_data = {{EXT_W{cnt_w[0][CNT_W-1]}}, cnt_w[0]};
            ADR_CNT1: rd_data = {{EXT_W{cnt_w[1][CNT_W-1]}}, cnt_w[1]};
            ADR_OVF:  rd_data = {{(RD_W-NCTR){1'b0}}, ovf_w};
            default:  rd_data = '0;
        endcase
    end

    assign irq = |ovf_w;

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && wr_addr == ADR_OVF)) |=> irq);

endmodule

// File: tb/sim_pmu2_top.sv
`timescale 1ns/1ps
module sim_pmu2_top;

    localparam int LANES = 4;
    localparam int OCC_W = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_en = 1'b0;
    logic [2:0]             wr_addr = '0;
    logic [31:0]            wr_data = '0;
    logic [2:0]             rd_addr = '0;
    logic [39:0]            rd_data;
    logic [LANES*8-1:0]     ev_code = '0;
    logic [LANES*8-1:0]     ev_sub = '0;
    logic [LANES*OCC_W-1:0] ev_occ = '0;
    logic                   irq;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [2:0]  a;
        logic [39:0] e;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    always #10 clk = ~clk;

    pmu2_top #(.LANES(LANES), .OCC_W(OCC_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_code(ev_code), .ev_sub(ev_sub), .ev_occ(ev_occ),
        .irq(irq)
    );

    // monitor: pops expected reads and compares them
    initial begin
        rd_item_t it;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q[0];
            rd_addr = it.a;
            #1;
            total++;
            if (rd_data !== it.e) begin
                bad++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rd_data, it.e);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [39:0] e, input string tag);
        rd_item_t it;
        it.a = a;
        it.e = e;
        it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lane(input int i, input logic [7:0] c, input logic [7:0] s, input logic [OCC_W-1:0] o);
        ev_code[i*8 +: 8] = c;
        ev_sub[i*8 +: 8] = s;
        ev_occ[i*OCC_W +: OCC_W] = o;
    endtask

    task automatic lanes_off();
        ev_code = '0;
        ev_sub = '0;
        ev_occ = '0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic occ0(input logic [OCC_W-1:0] o);
        ev_occ[0 +: OCC_W] = o;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cycles(2);
        rst_n = 1'b1;
        cycles(1);

        // reset state
        expect_rd(3'd0, 40'h0, "R1 reset sel0");
        expect_rd(3'd3, 40'h0, "R1 reset cnt1");
        expect_rd(3'd4, 40'h0, "R1 reset status");
        expect_irq(1'b0, "R9 reset irq");

        // R1 R2: program, match by code and sub-type overlap
        wr(3'd0, 32'h0040_0143);
        wr(3'd1, 32'h0000_FF80);
        expect_rd(3'd0, 40'h00_0040_0143, "R1 sel0 readback");
        lane(0, 8'h43, 8'h01, 3'd3);
        lane(1, 8'h43, 8'h02, 3'd2);
        lane(2, 8'h80, 8'h10, 3'd1);
        cycles(5);
        lanes_off();
        expect_rd(3'd2, 40'd15, "R2 cnt0 sum with mask overlap");
        expect_rd(3'd3, 40'd5, "R2 cnt1 mask all");

        // R3: run bit only in selector 0
        wr(3'd0, 32'h0000_0143);
        wr(3'd1, 32'h0040_FF80);
        expect_rd(3'd1, 40'h00_0040_FF80, "R1 sel1 readback");
        lane(0, 8'h43, 8'h01, 3'd3);
        lane(2, 8'h80, 8'h10, 3'd1);
        cycles(3);
        lanes_off();
        expect_rd(3'd2, 40'd15, "R3 cnt0 stopped");
        expect_rd(3'd3, 40'd5, "R3 cnt1 ignores own run bit");

        // R10 R4: write low 32 bits, sign-extended readback
        wr(3'd2, 32'h8000_0005);
        expect_rd(3'd2, 40'hFF_8000_0005, "R4 sign extension");
        wr(3'd3, 32'h7FFF_FFFF);
        expect_rd(3'd3, 40'h00_7FFF_FFFF, "R4 positive top byte");
        wr(3'd0, 32'h0040_0143);
        lane(0, 8'h43, 8'h01, 3'd3);
        wr(3'd2, 32'd100);
        lanes_off();
        expect_rd(3'd2, 40'd100, "R10 write wins over count");

        // R5: quiet selector
        wr(3'd1, 32'h0000_002E);
        lane(0, 8'h2E, 8'hFF, 3'd7);
        cycles(4);
        lanes_off();
        expect_rd(3'd3, 40'h00_7FFF_FFFF, "R5 quiet holds");

        // R6: counter-bound codes
        wr(3'd0, 32'h0040_FF11);
        wr(3'd1, 32'h0000_FF11);
        lane(0, 8'h11, 8'h01, 3'd2);
        cycles(3);
        lanes_off();
        expect_rd(3'd2, 40'd100, "R6 code 0x11 blocked on cnt0");
        expect_rd(3'd3, 40'hFF_8000_0005, "R6 code 0x11 on cnt1");
        wr(3'd0, 32'h0040_FF14);
        wr(3'd1, 32'h0000_FF14);
        lane(0, 8'h14, 8'h01, 3'd1);
        cycles(4);
        lanes_off();
        expect_rd(3'd2, 40'd104, "R6 code 0x14 on cnt0");
        expect_rd(3'd3, 40'hFF_8000_0005, "R6 code 0x14 blocked on cnt1");

        // R7: threshold and invert
        wr(3'd0, 32'h0000_0000);
        wr(3'd2, 32'd0);
        wr(3'd3, 32'd0);
        wr(3'd1, 32'h0380_FF43);
        lane(0, 8'h43, 8'h01, 3'd5);
        wr(3'd0, 32'h0340_FF43);
        occ0(3'd5);
        occ0(3'd2);
        occ0(3'd3);
        occ0(3'd0);
        occ0(3'd4);
        ev_occ[0 +: OCC_W] = 3'd4;
        wr(3'd0, 32'h0300_FF43);
        lanes_off();
        expect_rd(3'd2, 40'd4, "R7 at-or-above threshold");
        expect_rd(3'd3, 40'd2, "R7 inverted below threshold");

        // R8: edge mode
        wr(3'd2, 32'd0);
        wr(3'd1, 32'h0000_002E);
        wr(3'd0, 32'h0244_FF43);
        lane(0, 8'h43, 8'h01, 3'd0);
        occ0(3'd3);
        occ0(3'd3);
        occ0(3'd0);
        occ0(3'd2);
        occ0(3'd5);
        occ0(3'd1);
        occ0(3'd2);
        ev_occ[0 +: OCC_W] = 3'd0;
        wr(3'd0, 32'h0204_FF43);
        lanes_off();
        expect_rd(3'd2, 40'd3, "R8 rising transitions only");

        // R9: preload negated period, wrap, sticky flag
        wr(3'd2, 32'hFFFF_FFF0);
        wr(3'd3, 32'd0);
        wr(3'd1, 32'h0000_FF43);
        wr(3'd0, 32'h0040_FF43);
        lane(0, 8'h43, 8'h01, 3'd4);
        cycles(3);
        expect_rd(3'd2, 40'hFF_FFFF_FFFC, "R9 before wrap");
        expect_irq(1'b0, "R9 no irq before wrap");
        cycles(1);
        expect_irq(1'b1, "R9 irq on wrap");
        ev_occ = '0;
        wr(3'd0, 32'h0000_FF43);
        lanes_off();
        expect_rd(3'd2, 40'h0, "R9 wrapped value");
        expect_rd(3'd3, 40'd16, "R2 cnt1 shared events");
        expect_rd(3'd4, 40'h1, "R9 status flag 0");
        wr(3'd4, 32'h1);
        expect_rd(3'd4, 40'h0, "R9 flag cleared");
        expect_irq(1'b0, "R9 irq cleared");

        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0040_002E);
        lane(0, 8'h43, 8'h01, 3'd1);
        cycles(1);
        lanes_off();
        cycles(3);
        expect_rd(3'd3, 40'h0, "R9 cnt1 wrapped");
        expect_rd(3'd2, 40'h0, "R5 cnt0 quiet during wrap");
        expect_rd(3'd4, 40'h2, "R9 status flag 1 sticky");
        expect_irq(1'b1, "R9 irq sticky");
        wr(3'd4, 32'h3);
        expect_irq(1'b0, "R9 irq cleared again");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule